// File: doc/BRIEF.md
# Interrupt Pending and In-Service Tracker

This block sits between a set of interrupt input pins and a delivery path toward processor-side interrupt logic. Every pin has a trigger kind, a mask bit and a vector number, supplied as flat configuration inputs. The block turns input changes into pending requests. Each clock it picks the highest-numbered pending pin that is not already being serviced and hands it to a downstream consumer over a valid/ready port. It records level-triggered pins as in-service until an end-of-interrupt (EOI) naming their vector arrives.

An EOI carries only a vector number. The block maps it back to a pin with a lowest-index-first search over the vector table, and the highest pin is left out of that search. An EOI that finds no pin, or finds a pin that is not in service, is flagged as unmatched. A sticky interrupt-present flag is raised by any accepted input event and cleared by an acknowledge input. The pending and in-service vectors are visible as outputs.

Top module: `irq_track`

## Requirements
- R1: Pin 0 never produces an input event. Its pending bit stays 0, it never raises `irq_present`, and it is never delivered.
- R2: While `ctl_enable` is 0, or while a pin's `pin_masked` bit is 1, changes on that pin are ignored. The pending bits and `irq_present` are left alone, and a level that is already held when the pin becomes accepted again produces no event.
- R3: For a pin with `pin_is_level`=1, a low-to-high change sets its pending bit and a high-to-low change clears it. Both changes take effect at the next clock edge.
- R4: For a pin with `pin_is_level`=0, a low-to-high change sets its pending bit. A high-to-low change never clears it.
- R5: The candidates are the pins that are pending and not in service. One candidate is taken per clock, highest index first, and only when the delivery slot is free (`dlv_valid`=0 or `dlv_ready`=1). While `dlv_valid`=1 and `dlv_ready`=0, `dlv_pin` and `dlv_vec` hold steady.
- R6: When an unmasked candidate is taken, the next edge sets `dlv_valid` and loads `dlv_pin` and its vector into `dlv_vec`. The pin's pending bit is cleared. Its in-service bit is set only when the pin is level-triggered.
- R7: When the candidate taken is masked, its pending bit is cleared, nothing is delivered and its in-service bit is not set.
- R8: A pin whose in-service bit is set is not a candidate. It stays pending until an EOI clears its in-service bit, and it is delivered on the edge after that.
- R9: On `eoi_valid`, the pin chosen is the lowest index in 0..N-2 whose vector equals `eoi_vec`. If that pin's in-service bit is set, it is cleared at the same edge. Other pins with the same vector, and pin N-1, are left alone.
- R10: `eoi_miss` is 1 for exactly the cycle after an EOI when the chosen pin is not in service or no pin matches. Otherwise it is 0.
- R11: `irq_present` goes to 1 on the edge after any accepted input event. It goes to 0 on the edge after `ack` when no event arrives in that cycle, and a new event takes priority over `ack`.
- R12: After synchronous reset, the pending, in-service, `dlv_valid`, `eoi_miss` and `irq_present` outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Controller enable; 0 ignores all pin changes |
| pin_in | input | N | Interrupt input levels, one per pin |
| pin_is_level | input | N | Per-pin trigger kind: 1 level, 0 edge |
| pin_masked | input | N | Per-pin mask, 1 = masked |
| pin_vec | input | N*VW | Per-pin vector numbers, pin i at bits [i*VW +: VW] |
| ack | input | 1 | Acknowledge, clears irq_present |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Consumer accepts the delivery request |
| dlv_pin | output | log2(N) | Pin index of the delivery request |
| dlv_vec | output | VW | Vector of the delivered pin |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VW | Vector carried by the EOI |
| eoi_miss | output | 1 | EOI found no in-service pin |
| irq_present | output | 1 | Interrupt-present flag |
| pending | output | N | Pending vector |
| in_service | output | N | In-service vector |

## Verification
The hardest state to reach is a masked pin that is still pending when it is chosen, because an unstalled block takes every pending pin on the next clock. The bench holds `dlv_ready` low so that one delivery occupies the slot and the other pending bits pile up. It then masks one of those pins and releases the stall, so the masked pin is taken and discarded in its own cycle. The same stall window is used to show that a falling level pin withdraws its request and a falling edge pin does not. Duplicate vectors and a vector on the top pin are used to show which pin an EOI picks.

// File: rtl/irq_track_pkg.sv
package irq_track_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  function automatic bit trig_is_level(input logic t);
    return trig_e'(t) == TRIG_LEVEL;
  endfunction

endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctl_enable,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] pin_is_level,
  input  logic [N-1:0] pin_masked,
  output logic [N-1:0] ev_set,
  output logic [N-1:0] ev_clr
);
  import irq_track_pkg::*;

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_in;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pin
      localparam bit LIVE = (i != 0);
      logic accept;
      logic rise;
      logic fall;
      assign accept = LIVE && ctl_enable && !pin_masked[i];
      assign rise   = pin_in[i] && !prev_q[i];
      assign fall   = !pin_in[i] && prev_q[i];
      assign ev_set[i] = accept && rise;
      assign ev_clr[i] = accept && fall && trig_is_level(pin_is_level[i]);
    end
  endgenerate

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match #(
  parameter int N  = 16,
  parameter int VW = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N*VW-1:0] pin_vec,
  input  logic [VW-1:0]   eoi_vec,
  output logic            hit,
  output logic [IW-1:0]   hit_idx
);
  localparam int SEARCH = N - 1;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = SEARCH - 1; i >= 0; i--) begin
      if (pin_vec[i*VW +: VW] == eoi_vec) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_track.sv
module irq_track #(
  parameter int N  = 16,
  parameter int VW = 8,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_enable,
  input  logic [N-1:0]    pin_in,
  input  logic [N-1:0]    pin_is_level,
  input  logic [N-1:0]    pin_masked,
  input  logic [N*VW-1:0] pin_vec,
  input  logic            ack,
  output logic            dlv_valid,
  input  logic            dlv_ready,
  output logic [IW-1:0]   dlv_pin,
  output logic [VW-1:0]   dlv_vec,
  input  logic            eoi_valid,
  input  logic [VW-1:0]   eoi_vec,
  output logic            eoi_miss,
  output logic            irq_present,
  output logic [N-1:0]    pending,
  output logic [N-1:0]    in_service
);
  import irq_track_pkg::*;

  logic [N-1:0]  pend_q, isv_q;
  logic [N-1:0]  ev_set, ev_clr;
  logic          pick_any;
  logic [IW-1:0] pick_idx;
  logic          eoi_hit;
  logic [IW-1:0] eoi_idx;
  logic          dlv_valid_q, eoi_miss_q, present_q;
  logic [IW-1:0] dlv_pin_q;
  logic [VW-1:0] dlv_vec_q;

  logic          slot_free, do_svc, svc_live, eoi_ok;
  logic [N-1:0]  svc_bit, svc_clr, isv_set, eoi_clr;

  irq_pin_capture #(.N(N)) u_cap (
    .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .pin_in(pin_in),
    .pin_is_level(pin_is_level), .pin_masked(pin_masked),
    .ev_set(ev_set), .ev_clr(ev_clr)
  );

  irq_prio_pick #(.N(N), .IW(IW)) u_pick (
    .req(pend_q & ~isv_q), .any(pick_any), .idx(pick_idx)
  );

  irq_eoi_match #(.N(N), .VW(VW), .IW(IW)) u_eoi (
    .pin_vec(pin_vec), .eoi_vec(eoi_vec), .hit(eoi_hit), .hit_idx(eoi_idx)
  );

  always_comb begin
    slot_free = !dlv_valid_q || dlv_ready;
    do_svc    = slot_free && pick_any;
    svc_live  = do_svc && !pin_masked[pick_idx];
    svc_bit   = N'(1) << pick_idx;
    svc_clr   = do_svc ? svc_bit : '0;
    isv_set   = (svc_live && trig_is_level(pin_is_level[pick_idx])) ? svc_bit : '0;
    eoi_ok    = eoi_valid && eoi_hit && isv_q[eoi_idx];
    eoi_clr   = eoi_ok ? (N'(1) << eoi_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= '0;
      isv_q       <= '0;
      dlv_valid_q <= 1'b0;
      dlv_pin_q   <= '0;
      dlv_vec_q   <= '0;
      eoi_miss_q  <= 1'b0;
      present_q   <= 1'b0;
    end else begin
      pend_q     <= ((pend_q & ~svc_clr) & ~ev_clr) | ev_set;
      isv_q      <= (isv_q & ~eoi_clr) | isv_set;
      eoi_miss_q <= eoi_valid && !eoi_ok;
      if (svc_live) begin
        dlv_valid_q <= 1'b1;
        dlv_pin_q   <= pick_idx;
        dlv_vec_q   <= pin_vec[pick_idx*VW +: VW];
      end else if (dlv_ready) begin
        dlv_valid_q <= 1'b0;
      end
      if (|(ev_set | ev_clr)) present_q <= 1'b1;
      else if (ack)           present_q <= 1'b0;
    end
  end

  assign dlv_valid   = dlv_valid_q;
  assign dlv_pin     = dlv_pin_q;
  assign dlv_vec     = dlv_vec_q;
  assign eoi_miss    = eoi_miss_q;
  assign irq_present = present_q;
  assign pending     = pend_q;
  assign in_service  = isv_q;

endmodule

// File: rtl/irq_track_chk.sv
module irq_track_chk #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_enable,
  input logic [N-1:0]  pin_is_level,
  input logic          dlv_valid,
  input logic          dlv_ready,
  input logic [IW-1:0] dlv_pin,
  input logic          eoi_valid,
  input logic          eoi_miss,
  input logic          irq_present,
  input logic [N-1:0]  pending,
  input logic [N-1:0]  in_service
);

  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_pin));

  a_r1_pin0_never_delivered: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> dlv_pin != '0);

  a_r1_pin0_never_pending: assert property (@(posedge clk) disable iff (rst)
    !pending[0]);

  a_r6_edge_not_in_service: assert property (@(posedge clk) disable iff (rst)
    (in_service & ~$past(in_service) & ~$past(pin_is_level)) == '0);

  a_r6_new_service_delivered: assert property (@(posedge clk) disable iff (rst)
    |(in_service & ~$past(in_service)) |-> dlv_valid);

  a_r9_clear_needs_eoi: assert property (@(posedge clk) disable iff (rst)
    |($past(in_service) & ~in_service) |-> $past(eoi_valid));

  a_r9_single_clear: assert property (@(posedge clk) disable iff (rst)
    $countones($past(in_service) & ~in_service) <= 1);

  a_r10_miss_after_eoi: assert property (@(posedge clk) disable iff (rst)
    eoi_miss |-> $past(eoi_valid));

  a_r11_flag_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_present) |-> $past(ctl_enable));

endmodule

bind irq_track irq_track_chk #(.N(N), .IW(IW)) u_irq_track_chk (
  .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .pin_is_level(pin_is_level),
  .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
  .eoi_valid(eoi_valid), .eoi_miss(eoi_miss), .irq_present(irq_present),
  .pending(pending), .in_service(in_service)
);

// File: tb/irq_track_test.sv
module irq_track_test;
  localparam int N  = 16;
  localparam int VW = 8;
  localparam int IW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ctl_enable = 1'b1;
  logic [N-1:0]    pin_in = '0;
  logic [N-1:0]    pin_is_level = '0;
  logic [N-1:0]    pin_masked = '0;
  logic [N*VW-1:0] pin_vec;
  logic            ack = 1'b0;
  logic            dlv_valid;
  logic            dlv_ready = 1'b1;
  logic [IW-1:0]   dlv_pin;
  logic [VW-1:0]   dlv_vec;
  logic            eoi_valid = 1'b0;
  logic [VW-1:0]   eoi_vec = '0;
  logic            eoi_miss;
  logic            irq_present;
  logic [N-1:0]    pending;
  logic [N-1:0]    in_service;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_track #(.N(N), .VW(VW)) uut (
    .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .pin_in(pin_in),
    .pin_is_level(pin_is_level), .pin_masked(pin_masked), .pin_vec(pin_vec),
    .ack(ack), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
    .dlv_vec(dlv_vec), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .eoi_miss(eoi_miss), .irq_present(irq_present), .pending(pending),
    .in_service(in_service)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic send_eoi(input logic [VW-1:0] v);
    eoi_vec = v; eoi_valid = 1'b1; step(1); eoi_valid = 1'b0;
  endtask

  task automatic t_reset();
    step(3); rst = 1'b0; step(1);
    chk("R12 pending", 32'(pending), 0);
    chk("R12 in_service", 32'(in_service), 0);
    chk("R12 dlv_valid", 32'(dlv_valid), 0);
    chk("R12 eoi_miss", 32'(eoi_miss), 0);
    chk("R12 irq_present", 32'(irq_present), 0);
  endtask

  task automatic t_level();
    pin_is_level[5] = 1'b1; pin_in[5] = 1'b1; step(1);
    chk("R3 level rise pending", 32'(pending), 32'h20);
    chk("R11 flag set", 32'(irq_present), 1);
    step(1);
    chk("R6 deliver valid", 32'(dlv_valid), 1);
    chk("R6 deliver pin", 32'(dlv_pin), 5);
    chk("R6 deliver vec", 32'(dlv_vec), 32'h25);
    chk("R6 level in service", 32'(in_service), 32'h20);
    chk("R6 pending cleared", 32'(pending), 0);
    do_ack();
    chk("R11 ack clears", 32'(irq_present), 0);
    chk("R5 slot drains", 32'(dlv_valid), 0);
    pin_in[5] = 1'b0; step(1);
    chk("R3 level fall event", 32'(irq_present), 1);
    pin_in[5] = 1'b1; step(2);
    chk("R8 in-service blocks", 32'(pending), 32'h20);
    chk("R8 not delivered", 32'(dlv_valid), 0);
    do_ack();
  endtask

  task automatic t_edge();
    pin_in[3] = 1'b1; step(1);
    chk("R4 edge rise pending", 32'(pending), 32'h28);
    step(1);
    chk("R6 edge deliver pin", 32'(dlv_pin), 3);
    chk("R6 edge no in-service", 32'(in_service), 32'h20);
    pin_in[3] = 1'b0; step(1);
    chk("R4 edge fall no pending", 32'(pending), 32'h20);
    do_ack();
  endtask

  task automatic t_order();
    dlv_ready = 1'b0;
    pin_in[2] = 1'b1; pin_in[4] = 1'b1; pin_in[7] = 1'b1; step(1);
    chk("R5 pending set", 32'(pending), 32'hB4);
    step(1);
    chk("R5 highest first", 32'(dlv_pin), 7);
    step(1);
    chk("R5 stall holds pin", 32'(dlv_pin), 7);
    chk("R5 stall holds rest", 32'(pending), 32'h34);
    dlv_ready = 1'b1; step(1);
    chk("R5 second pin", 32'(dlv_pin), 4);
    step(1);
    chk("R5 third pin", 32'(dlv_pin), 2);
    step(1);
    chk("R5 drained", 32'(dlv_valid), 0);
    pin_in[2] = 1'b0; pin_in[4] = 1'b0; pin_in[7] = 1'b0; step(1);
    do_ack();
  endtask

  task automatic t_stall_mix();
    dlv_ready = 1'b0; pin_is_level[8] = 1'b1;
    pin_in[8] = 1'b1; pin_in[10] = 1'b1; pin_in[11] = 1'b1; pin_in[12] = 1'b1;
    step(2);
    chk("R5 slot pin 12", 32'(dlv_pin), 12);
    chk("R3 level pending held", 32'(pending), 32'h0D20);
    pin_in[8] = 1'b0; step(1);
    chk("R3 level fall clears", 32'(pending), 32'h0C20);
    pin_in[11] = 1'b0; step(1);
    chk("R4 edge fall keeps", 32'(pending), 32'h0C20);
    pin_masked[10] = 1'b1; dlv_ready = 1'b1; step(1);
    chk("R6 pin 11 delivered", 32'(dlv_pin), 11);
    step(1);
    chk("R7 masked no delivery", 32'(dlv_valid), 0);
    chk("R7 masked pending cleared", 32'(pending), 32'h20);
    chk("R7 masked no in-service", 32'(in_service), 32'h20);
    pin_in[10] = 1'b0; pin_in[12] = 1'b0; step(1);
    pin_masked[10] = 1'b0; step(1);
    do_ack();
  endtask

  task automatic t_ignore();
    pin_in[0] = 1'b1; step(2);
    chk("R1 pin0 pending", 32'(pending), 32'h20);
    chk("R1 pin0 flag", 32'(irq_present), 0);
    chk("R1 pin0 no delivery", 32'(dlv_valid), 0);
    ctl_enable = 1'b0; pin_in[6] = 1'b1; step(2);
    chk("R2 disabled pending", 32'(pending), 32'h20);
    chk("R2 disabled flag", 32'(irq_present), 0);
    ctl_enable = 1'b1; step(2);
    chk("R2 held level no event", 32'(pending), 32'h20);
    pin_masked[9] = 1'b1; pin_in[9] = 1'b1; step(2);
    chk("R2 masked pending", 32'(pending), 32'h20);
    chk("R2 masked flag", 32'(irq_present), 0);
  endtask

  task automatic t_eoi();
    send_eoi(8'h25);
    chk("R9 eoi clears pin5", 32'(in_service), 0);
    chk("R10 no miss", 32'(eoi_miss), 0);
    step(0);
    @(posedge clk); #1;
    chk("R8 redelivered after eoi", 32'(dlv_pin), 5);
    chk("R8 back in service", 32'(in_service), 32'h20);
    send_eoi(8'h99);
    chk("R10 unknown vector miss", 32'(eoi_miss), 1);
    step(1);
    chk("R10 miss one cycle", 32'(eoi_miss), 0);
    pin_is_level[13] = 1'b1; pin_is_level[14] = 1'b1; pin_is_level[15] = 1'b1;
    pin_in[13] = 1'b1; pin_in[14] = 1'b1; pin_in[15] = 1'b1;
    step(4);
    chk("R6 three level pins in service", 32'(in_service), 32'hE020);
    send_eoi(8'h40);
    chk("R9 lowest duplicate cleared", 32'(in_service), 32'hC020);
    send_eoi(8'h40);
    chk("R10 duplicate second miss", 32'(eoi_miss), 1);
    chk("R9 higher duplicate kept", 32'(in_service), 32'hC020);
    send_eoi(8'h50);
    chk("R10 last pin miss", 32'(eoi_miss), 1);
    chk("R9 last pin excluded", 32'(in_service), 32'hC020);
  endtask

  initial begin
    for (int i = 0; i < N; i++) pin_vec[i*VW +: VW] = VW'(8'h20 + i);
    pin_vec[13*VW +: VW] = 8'h40;
    pin_vec[14*VW +: VW] = 8'h40;
    pin_vec[15*VW +: VW] = 8'h50;
    t_reset();
    t_level();
    t_edge();
    t_order();
    t_stall_mix();
    t_ignore();
    t_eoi();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule